// File: doc/BRIEF.md
# Row-Parallel Set-Address Signature Compressor

This block reduces the contents of a bit-organised memory array to a short signature: the bitwise XOR of the full address of every cell holding a one. A full address is the row address in the upper bits and the column address in the lower bits. Each clock cycle a controller presents one complete row of data together with that row's address. The block forms that row's whole contribution to the signature in a single cycle and folds it into an accumulator. After every row has been presented once, starting from a cleared accumulator, the accumulator holds the signature of the whole array.

The row contribution has two fields. The upper field is the row address when the row holds an odd number of ones, and zero otherwise. Each bit of the lower field is the parity of the data at the columns whose column address has that bit set. The block also puts the current row's contribution on an output without a register, so a surrounding controller can fold it into a second register of its own, for example a reference copy that has to track writes. The XOR reduction can be built either as an explicit balanced tree or as a plain reduction operator, chosen by a parameter.

Top module: `addr_sig_accum`

## Requirements
- R1: After reset, and in the cycle after `clr` is sampled high, `sig` is zero.
- R2: When `clr` and `row_vld` are both high at a clock edge, `clr` wins and `sig` becomes zero.
- R3: The upper field of `row_sig` (bits SW-1 down to CW) equals `row_addr` when `row_data` holds an odd number of ones, and zero when it holds an even number.
- R4: Bit i of the lower field of `row_sig` (bits CW-1 down to 0) is the XOR of `row_data[c]` over every column c whose binary index has bit i set; `row_data[c]` is the cell at column address c.
- R5: When `row_vld` is high and `clr` low at a clock edge, `sig` becomes its previous value XOR `row_sig`, visible one cycle later.
- R6: When neither `row_vld` nor `clr` is high, `sig` keeps its value whatever `row_addr` and `row_data` carry.
- R7: After a clear followed by one presentation of every row, `sig` equals the XOR of {row, column} over all cells holding a one.
- R8: If exactly one cell of the array is flipped, the XOR of the signatures before and after equals that cell's full address {row, column}.
- R9: For a 4x4 array with rows 0..3 holding columns 0..3 as 1010, 0111, 0011, 0100, the row contributions are 0010, 0100, 0001, 1101 and the full signature is 1010.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of the accumulator |
| row_vld | input | 1 | Fold the present row's contribution into the accumulator |
| row_addr | input | RW | Address of the presented row |
| row_data | input | COLS | Row data, bit c is column c |
| row_sig | output | SW | Combinational contribution of the presented row |
| sig | output | SW | Accumulated signature |

## Verification
The hardest situation to reach from the ports is a single upset cell, because it only shows as the difference between two complete scans of the same image. The bench keeps its own image of the array, scans it, flips one randomly chosen cell, scans again and compares the difference of the two signatures with that cell's address. Rows of odd parity at non-zero addresses, idle cycles carrying junk data, and clear colliding with a valid row are mixed into the random scans so that each path into the accumulator is exercised.

// File: rtl/sig_pkg.sv
package sig_pkg;

   typedef enum logic {
      XR_REDUCE = 1'b0,
      XR_TREE   = 1'b1
   } xor_style_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/sig_xor_tree.sv
module sig_xor_tree #(
   parameter int unsigned          W     = 8,
   parameter sig_pkg::xor_style_e  STYLE = sig_pkg::XR_TREE
) (
   input  logic [W-1:0] din,
   output logic         par
);

   localparam int unsigned NODES = 2 * W - 1;

   generate
      if (STYLE == sig_pkg::XR_TREE) begin : g_tree
         // heap-ordered tree: leaves at W-1..2W-2, root at 0
         logic [NODES-1:0] node;
         for (genvar k = 0; k < W; k++) begin : g_leaf
            assign node[W-1+k] = din[k];
         end
         for (genvar j = 0; j < W - 1; j++) begin : g_inner
            assign node[j] = node[2*j+1] ^ node[2*j+2];
         end
         assign par = node[0];
      end else begin : g_reduce
         assign par = ^din;
      end
   endgenerate

endmodule

// File: rtl/sig_row_char.sv
module sig_row_char #(
   parameter int unsigned          ROWS  = 8,
   parameter int unsigned          COLS  = 8,
   parameter sig_pkg::xor_style_e  STYLE = sig_pkg::XR_TREE
) (
   input  logic [$clog2(ROWS)-1:0]             row_addr,
   input  logic [COLS-1:0]                     row_data,
   output logic [$clog2(ROWS)+$clog2(COLS)-1:0] part
);

   localparam int unsigned RW = $clog2(ROWS);
   localparam int unsigned CW = $clog2(COLS);
   localparam int unsigned SW = RW + CW;

   logic          row_odd;
   logic [CW-1:0] lane_par;

   sig_xor_tree #(.W(COLS), .STYLE(STYLE)) u_row_par (
      .din (row_data),
      .par (row_odd)
   );

   generate
      for (genvar i = 0; i < CW; i++) begin : g_lane
         logic [COLS-1:0] masked;
         for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam bit HAS_BIT = ((c >> i) & 1) == 1;
            assign masked[c] = HAS_BIT ? row_data[c] : 1'b0;
         end
         sig_xor_tree #(.W(COLS), .STYLE(STYLE)) u_lane_par (
            .din (masked),
            .par (lane_par[i])
         );
      end
   endgenerate

   assign part = {(row_odd ? row_addr : {RW{1'b0}}), lane_par};

   // R3: upper field tracks the count of ones in the row
   always_comb begin
      a_r3_row_field : assert (part[SW-1:CW] ==
                               (($countones(row_data) % 2 == 1) ? row_addr : {RW{1'b0}}));
   end

   // R4: each lower bit counts ones at columns with that address bit set
   logic [CW-1:0] lane_ref;
   always_comb begin
      lane_ref = '0;
      for (int i = 0; i < CW; i++) begin
         for (int c = 0; c < COLS; c++) begin
            if (row_data[c] && (((c >> i) & 1) == 1)) lane_ref[i] = ~lane_ref[i];
         end
      end
      a_r4_col_field : assert (part[CW-1:0] == lane_ref);
   end

endmodule

// File: rtl/sig_accum.sv
module sig_accum #(
   parameter int unsigned SW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          vld,
   input  logic [SW-1:0] part,
   output logic [SW-1:0] sig
);

   logic [SW-1:0] acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc_q <= '0;
      else if (clr) acc_q <= '0;
      else if (vld) acc_q <= acc_q ^ part;
   end

   assign sig = acc_q;

   a_r1_clear_zero : assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (sig == '0));

   a_r2_clear_beats_valid : assert property (@(posedge clk) disable iff (!rst_n)
      (clr && vld) |=> (sig == '0));

   a_r6_idle_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !vld) |=> $stable(sig));

endmodule

// File: rtl/addr_sig_accum.sv
module addr_sig_accum #(
   parameter int unsigned          ROWS  = 8,
   parameter int unsigned          COLS  = 8,
   parameter sig_pkg::xor_style_e  STYLE = sig_pkg::XR_TREE
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  clr,
   input  logic                                  row_vld,
   input  logic [$clog2(ROWS)-1:0]               row_addr,
   input  logic [COLS-1:0]                       row_data,
   output logic [$clog2(ROWS)+$clog2(COLS)-1:0]  row_sig,
   output logic [$clog2(ROWS)+$clog2(COLS)-1:0]  sig
);

   localparam int unsigned RW = $clog2(ROWS);
   localparam int unsigned CW = $clog2(COLS);
   localparam int unsigned SW = RW + CW;

   generate
      if (!sig_pkg::is_pow2(ROWS)) begin : g_bad_rows
         $error("ROWS must be a power of two, at least 2");
      end
      if (!sig_pkg::is_pow2(COLS)) begin : g_bad_cols
         $error("COLS must be a power of two, at least 2");
      end
   endgenerate

   sig_row_char #(.ROWS(ROWS), .COLS(COLS), .STYLE(STYLE)) u_row (
      .row_addr (row_addr),
      .row_data (row_data),
      .part     (row_sig)
   );

   sig_accum #(.SW(SW)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .vld   (row_vld),
      .part  (row_sig),
      .sig   (sig)
   );

   // R5: a valid row folds its contribution in one cycle
   a_r5_fold_row : assert property (@(posedge clk) disable iff (!rst_n)
      (row_vld && !clr) |=> (sig == ($past(sig) ^ $past(row_sig))));

endmodule

// File: tb/addr_sig_accum_tb.sv
`timescale 1ns/1ps
module addr_sig_accum_tb;

   localparam int R  = 8;
   localparam int C  = 8;
   localparam int RW = 3;
   localparam int CW = 3;
   localparam int SW = RW + CW;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          clr, vld;
   logic [RW-1:0] addr;
   logic [C-1:0]  data;
   logic [SW-1:0] rsig, sig;

   logic          s_clr, s_vld;
   logic [1:0]    s_addr;
   logic [3:0]    s_data;
   logic [3:0]    s_rsig, s_sig;

   int  total = 0;
   int  fails = 0;
   bit  done  = 1'b0;

   logic [C-1:0]  mem [R];
   logic [SW-1:0] exp_sig;

   always #2.5 clk = ~clk;

   addr_sig_accum #(.ROWS(R), .COLS(C)) u_dut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .row_vld(vld),
      .row_addr(addr), .row_data(data), .row_sig(rsig), .sig(sig)
   );

   addr_sig_accum #(.ROWS(4), .COLS(4), .STYLE(sig_pkg::XR_REDUCE)) u_dut_small (
      .clk(clk), .rst_n(rst_n), .clr(s_clr), .row_vld(s_vld),
      .row_addr(s_addr), .row_data(s_data), .row_sig(s_rsig), .sig(s_sig)
   );

   task automatic chk(input bit ok, input string req,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // independent model: XOR of {row, col} over set cells
   function automatic logic [SW-1:0] ref_row(input logic [RW-1:0] a, input logic [C-1:0] d);
      logic [SW-1:0] r = '0;
      for (int c = 0; c < C; c++) if (d[c]) r ^= {a, CW'(c)};
      return r;
   endfunction

   function automatic logic [SW-1:0] ref_full();
      logic [SW-1:0] r = '0;
      for (int k = 0; k < R; k++) r ^= ref_row(RW'(k), mem[k]);
      return r;
   endfunction

   task automatic do_clear(input bit with_vld);
      @(negedge clk);
      clr = 1'b1; vld = with_vld; addr = RW'($urandom); data = C'($urandom | 1);
      @(posedge clk); #1;
      exp_sig = '0;
      if (with_vld) chk(sig == '0, "R2 clear over valid", sig, 0);
      else          chk(sig == '0, "R1 clear", sig, 0);
      clr = 1'b0;
   endtask

   task automatic present(input logic [RW-1:0] a, input logic [C-1:0] d);
      logic [SW-1:0] e;
      @(negedge clk);
      clr = 1'b0; vld = 1'b1; addr = a; data = d;
      #1;
      e = ref_row(a, d);
      chk(rsig[SW-1:CW] == e[SW-1:CW], "R3 row field", rsig, e);
      chk(rsig[CW-1:0]  == e[CW-1:0],  "R4 column field", rsig, e);
      @(posedge clk); #1;
      exp_sig ^= e;
      chk(sig == exp_sig, "R5 fold", sig, exp_sig);
      vld = 1'b0;
   endtask

   task automatic idle();
      @(negedge clk);
      clr = 1'b0; vld = 1'b0; addr = RW'($urandom); data = C'($urandom);
      @(posedge clk); #1;
      chk(sig == exp_sig, "R6 idle hold", sig, exp_sig);
   endtask

   task automatic scan(input bit with_idle);
      for (int k = 0; k < R; k++) begin
         present(RW'(k), mem[k]);
         if (with_idle && ($urandom % 3 == 0)) idle();
      end
   endtask

   task automatic small_row(input logic [1:0] a, input logic [3:0] d, input logic [3:0] e);
      @(negedge clk);
      s_clr = 1'b0; s_vld = 1'b1; s_addr = a; s_data = d;
      #1;
      chk(s_rsig == e, "R9 4x4 row contribution", s_rsig, e);
      @(posedge clk); #1;
      s_vld = 1'b0;
   endtask

   initial begin
      #1000000;
      if (!done) begin
         fails++; total++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      rst_n = 1'b0; clr = 1'b0; vld = 1'b0; addr = '0; data = '0;
      s_clr = 1'b0; s_vld = 1'b0; s_addr = '0; s_data = '0;
      exp_sig = '0;
      repeat (3) @(posedge clk);
      #1;
      chk(sig == '0,   "R1 reset", sig, 0);
      chk(s_sig == '0, "R1 reset small", s_sig, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R9: 4x4 worked case, bit c = column c
      small_row(2'd0, 4'b0101, 4'b0010);
      small_row(2'd1, 4'b1110, 4'b0100);
      small_row(2'd2, 4'b1100, 4'b0001);
      small_row(2'd3, 4'b0010, 4'b1101);
      chk(s_sig == 4'b1010, "R9 4x4 signature", s_sig, 4'b1010);

      // directed images: empty, full, checkerboard
      for (int k = 0; k < R; k++) mem[k] = '0;
      do_clear(1'b0); scan(1'b0);
      chk(sig == ref_full(), "R7 empty image", sig, ref_full());
      for (int k = 0; k < R; k++) mem[k] = '1;
      do_clear(1'b0); scan(1'b0);
      chk(sig == ref_full(), "R7 full image", sig, ref_full());
      for (int k = 0; k < R; k++) mem[k] = (k % 2 == 1) ? C'(8'hAA) : C'(8'h55);
      do_clear(1'b0); scan(1'b1);
      chk(sig == ref_full(), "R7 checkerboard", sig, ref_full());

      // random images with idle cycles carrying junk
      for (int t = 0; t < 12; t++) begin
         for (int k = 0; k < R; k++) mem[k] = C'($urandom);
         do_clear(1'b0); scan(1'b1);
         chk(sig == ref_full(), "R7 random image", sig, ref_full());
      end

      // clear colliding with a valid row
      present(RW'(5), C'(8'h13));
      do_clear(1'b1);
      idle();

      // single-cell flip
      for (int t = 0; t < 8; t++) begin
         logic [SW-1:0] s0;
         int fr, fc;
         for (int k = 0; k < R; k++) mem[k] = C'($urandom);
         do_clear(1'b0); scan(1'b0);
         s0 = sig;
         fr = $urandom % R; fc = $urandom % C;
         mem[fr][fc] = ~mem[fr][fc];
         do_clear(1'b0); scan(1'b1);
         chk((s0 ^ sig) == {RW'(fr), CW'(fc)}, "R8 single flip", s0 ^ sig, {RW'(fr), CW'(fc)});
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule